// File: doc/BRIEF.md
# Word/Byte Read-Only Memory Output and Identify Logic

This block models the device side of a 16-bit read-only memory that can also be read as 8 bits. A host drives active-low chip-select and output-enable strobes, a word/byte width select, a flag that stands for a high voltage on one address line, the word address, and the input side of the shared top-data/lowest-address pin. The block returns the data word and two lane enables. The enables stand in for tri-state control of the low byte lane (bits 7:0) and the high byte lane (bits 15:8).

In byte mode the shared pin becomes the address bit below the word address. The chosen half of the word is then steered onto the low lane. While the identify flag is raised, the block returns fixed manufacturer and device codes in place of array data. The contents come from a small synthesizable array whose values are computed at elaboration. A cycle counter models access latency. A move to a new page, a width change, an identify change or a deselect costs the full count. A move within the current page costs the shorter page count. A `data_valid` flag marks the cycles in which the output may be used.

Top module: `wbrom_reader`

## Requirements
- R1: While `ce_n` is 1, `lo_oe`, `hi_oe` and `data_valid` are 0 and `dq_out` is 0, whatever `oe_n` does.
- R2: While `ce_n` is 0 and `oe_n` is 1, `lo_oe`, `hi_oe` and `data_valid` are 0 and `dq_out` is 0.
- R3: In word mode (`word_mode`=1) with both strobes at 0, `lo_oe` and `hi_oe` are 1 and `dq_out` carries the full selected word. `a_m1` has no effect in this mode.
- R4: In byte mode (`word_mode`=0) with both strobes at 0, `hi_oe` is 0, `lo_oe` is 1 and `dq_out[15:8]` is 0. `dq_out[7:0]` carries word bits 15:8 when `a_m1` is 1 and word bits 7:0 when `a_m1` is 0.
- R5: Array word at address a reads as 16'hFFFF (blank) when a[2:0] is 3'b111. Otherwise it reads as (a*40503 + 4660) mod 65536.
- R6: With `id_hv`=1 and `addr[ADDR_W-1:1]` all zero, the selected word is 16'h00C2 when `addr[0]`=0 and 16'hB800 when `addr[0]`=1. This takes priority over the array. Word/byte steering still applies.
- R7: With `id_hv`=1 and any bit of `addr[ADDR_W-1:1]` set, the selected word is 16'hFFFF.
- R8: Full-access rule. A clock edge with `ce_n`=1 loads the counter with FULL_LAT (default 4). An edge at which {`id_hv`, `word_mode`, `addr[ADDR_W-1:PAGE_W]`} differs from its value at the previous edge loads FULL_LAT-1. Any other edge decrements a non-zero counter.
- R9: Page rule. An edge at which only {`addr[PAGE_W-1:0]`, and `a_m1` in byte mode} differs from the previous edge loads PAGE_LAT-1 (default 2) when the counter is at most PAGE_LAT. Otherwise it decrements the counter.
- R10: `data_valid` is 1 exactly when both strobes are 0, the counter is 0 and neither key of R8/R9 differs from its value at the last edge. `oe_n` does not affect the counter.
- R11: During reset `data_valid` is 0 and the counter holds FULL_LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| word_mode | input | 1 | 1: 16-bit reads, 0: 8-bit reads |
| id_hv | input | 1 | High-voltage identify flag |
| addr | input | ADDR_W | Word address |
| a_m1 | input | 1 | Shared pin used as sub-word address in byte mode |
| dq_out | output | 16 | Output data, 0 on disabled lanes |
| lo_oe | output | 1 | Drive enable for bits 7:0 |
| hi_oe | output | 1 | Drive enable for bits 15:8 |
| data_valid | output | 1 | Output data has met its access latency |

## Verification
The assertions check the lane-enable rules on every cycle: standby, output disable, word mode and byte mode. They also check that a disabled lane reads zero and that a page-level address change drops `data_valid` in the same cycle. The exact cycle in which `data_valid` returns after full and page moves can only be shown by the bench. So can the array values, blank locations, identify codes and byte steering. The bench uses a cycle-accurate reference built from the requirement text.

// File: rtl/wbrom_pkg.sv
package wbrom_pkg;
   localparam int WORD_W = 16;
   localparam int LANE_W = 8;
   localparam int N_LANES = WORD_W / LANE_W;
   localparam logic [WORD_W-1:0] BLANK_WORD = 16'hFFFF;

   // Content rule: every eighth location is left blank, the rest hold a hash.
   function automatic logic [WORD_W-1:0] rom_word(input int unsigned a);
      int unsigned v;
      if (a[2:0] == 3'b111) return BLANK_WORD;
      v = a * 32'd40503 + 32'd4660;
      return v[WORD_W-1:0];
   endfunction
endpackage

// File: rtl/wbrom_array.sv
module wbrom_array
   import wbrom_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] cells [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      assign cells[g] = rom_word(g);
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/wbrom_latency.sv
module wbrom_latency #(
   parameter int HI_W     = 8,
   parameter int LO_W     = 4,
   parameter int FULL_LAT = 4,
   parameter int PAGE_LAT = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce_n,
   input  logic [HI_W-1:0] hi_key,
   input  logic [LO_W-1:0] lo_key,
   output logic            ready
);
   localparam int CW = $clog2(FULL_LAT + 1);
   localparam logic [CW-1:0] FULL_C = CW'(FULL_LAT);
   localparam logic [CW-1:0] PAGE_C = CW'(PAGE_LAT);

   logic [HI_W-1:0] prev_hi;
   logic [LO_W-1:0] prev_lo;
   logic [CW-1:0]   cnt;
   logic            hi_chg, lo_chg;

   assign hi_chg = (hi_key != prev_hi);
   assign lo_chg = (lo_key != prev_lo);
   assign ready  = (cnt == '0) && !hi_chg && !lo_chg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_hi <= '0;
         prev_lo <= '0;
         cnt     <= FULL_C;
      end else begin
         prev_hi <= hi_key;
         prev_lo <= lo_key;
         if (ce_n)
            cnt <= FULL_C;
         else if (hi_chg)
            cnt <= FULL_C - 1'b1;
         else if (lo_chg)
            cnt <= (cnt > PAGE_C) ? cnt - 1'b1 : PAGE_C - 1'b1;
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/wbrom_steer.sv
module wbrom_steer
   import wbrom_pkg::*;
#(
   parameter int              ADDR_W   = 6,
   parameter logic [WORD_W-1:0] MFR_CODE = 16'h00C2,
   parameter logic [WORD_W-1:0] DEV_CODE = 16'hB800
) (
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              word_mode,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic              a_m1,
   input  logic [WORD_W-1:0] cell_word,
   output logic [WORD_W-1:0] dq,
   output logic [N_LANES-1:0] lane_on
);
   logic              driving;
   logic              rest_zero;
   logic [WORD_W-1:0] word;

   assign driving   = !ce_n && !oe_n;
   assign rest_zero = (addr[ADDR_W-1:1] == '0);

   always_comb begin
      if (id_hv)
         word = !rest_zero ? BLANK_WORD : (addr[0] ? DEV_CODE : MFR_CODE);
      else
         word = cell_word;
   end

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      if (g == 0) begin : g_low
         assign lane_on[g] = driving;
         assign dq[g*LANE_W +: LANE_W] = !driving ? '0 :
                (word_mode || !a_m1) ? word[LANE_W-1:0] : word[WORD_W-1:LANE_W];
      end else begin : g_high
         assign lane_on[g] = driving && word_mode;
         assign dq[g*LANE_W +: LANE_W] = lane_on[g] ? word[g*LANE_W +: LANE_W] : '0;
      end
   end
endmodule

// File: rtl/wbrom_reader.sv
module wbrom_reader
   import wbrom_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int PAGE_W   = 3,
   parameter int FULL_LAT = 4,
   parameter int PAGE_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              word_mode,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic              a_m1,
   output logic [WORD_W-1:0] dq_out,
   output logic              lo_oe,
   output logic              hi_oe,
   output logic              data_valid
);
   localparam int HI_W = ADDR_W - PAGE_W + 2;
   localparam int LO_W = PAGE_W + 1;

   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must lie in 1..ADDR_W-1");
   end
   if (PAGE_LAT < 1 || FULL_LAT < PAGE_LAT) begin : g_bad_lat
      $error("latencies need 1 <= PAGE_LAT <= FULL_LAT");
   end
   if (N_LANES != 2) begin : g_bad_lanes
      $error("word must be two byte lanes");
   end

   logic [WORD_W-1:0]  cell_word;
   logic [N_LANES-1:0] lane_on;
   logic [HI_W-1:0]    hi_key;
   logic [LO_W-1:0]    lo_key;
   logic               ready;

   assign hi_key = {id_hv, word_mode, addr[ADDR_W-1:PAGE_W]};
   assign lo_key = {addr[PAGE_W-1:0], a_m1 & !word_mode};

   wbrom_array #(.ADDR_W(ADDR_W)) u_array (
      .raddr (addr),
      .rdata (cell_word)
   );

   wbrom_steer #(.ADDR_W(ADDR_W)) u_steer (
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .word_mode (word_mode),
      .id_hv     (id_hv),
      .addr      (addr),
      .a_m1      (a_m1),
      .cell_word (cell_word),
      .dq        (dq_out),
      .lane_on   (lane_on)
   );

   wbrom_latency #(
      .HI_W(HI_W), .LO_W(LO_W), .FULL_LAT(FULL_LAT), .PAGE_LAT(PAGE_LAT)
   ) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_n   (ce_n),
      .hi_key (hi_key),
      .lo_key (lo_key),
      .ready  (ready)
   );

   assign lo_oe      = lane_on[0];
   assign hi_oe      = lane_on[1];
   assign data_valid = ready && !ce_n && !oe_n;
endmodule

// File: rtl/wbrom_props.sv
module wbrom_props #(
   parameter int ADDR_W = 6,
   parameter int PAGE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              word_mode,
   input logic [ADDR_W-1:0] addr,
   input logic [15:0]       dq_out,
   input logic              lo_oe,
   input logic              hi_oe,
   input logic              data_valid
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (!lo_oe && !hi_oe && !data_valid && dq_out == 16'h0));

   assert_oe_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_n) |-> (!lo_oe && !hi_oe && !data_valid && dq_out == 16'h0));

   assert_word_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && word_mode) |-> (lo_oe && hi_oe));

   assert_byte_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && !word_mode) |-> (lo_oe && !hi_oe && dq_out[15:8] == 8'h0));

   assert_page_move_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && addr[ADDR_W-1:PAGE_W] != $past(addr[ADDR_W-1:PAGE_W])) |-> !data_valid);

   assert_valid_needs_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> lo_oe);
endmodule

bind wbrom_reader wbrom_props #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_props (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .word_mode(word_mode),
   .addr(addr), .dq_out(dq_out), .lo_oe(lo_oe), .hi_oe(hi_oe),
   .data_valid(data_valid)
);

// File: tb/tb_wbrom_reader.sv
module tb_wbrom_reader;
   localparam int AW = 6, PW = 3, FULL = 4, PAGE = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, word_mode = 1'b1, id_hv = 1'b0, a_m1 = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [15:0] dq_out;
   logic lo_oe, hi_oe, data_valid;

   int tests = 0, fails = 0;

   // reference state (from R8/R9 text)
   int m_cnt = FULL;
   logic [AW-PW+1:0] m_hi;
   logic [PW:0]      m_lo;

   always #5 clk = ~clk;

   wbrom_reader #(.ADDR_W(AW), .PAGE_W(PW), .FULL_LAT(FULL), .PAGE_LAT(PAGE)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .word_mode(word_mode),
      .id_hv(id_hv), .addr(addr), .a_m1(a_m1), .dq_out(dq_out), .lo_oe(lo_oe),
      .hi_oe(hi_oe), .data_valid(data_valid)
   );

   function automatic logic [15:0] spec_cell(input int unsigned a);
      int unsigned v;
      if ((a % 8) == 7) return 16'hFFFF;  // R5 blank
      v = (a * 40503 + 4660) % 65536;     // R5 hash
      return v[15:0];
   endfunction

   function automatic logic [AW-PW+1:0] cur_hi();
      return {id_hv, word_mode, addr[AW-1:PW]};
   endfunction
   function automatic logic [PW:0] cur_lo();
      return {addr[PW-1:0], a_m1 & !word_mode};
   endfunction

   task automatic model_edge();
      if (ce_n) m_cnt = FULL;
      else if (cur_hi() != m_hi) m_cnt = FULL - 1;
      else if (cur_lo() != m_lo) m_cnt = (m_cnt > PAGE) ? m_cnt - 1 : PAGE - 1;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      m_hi = cur_hi();
      m_lo = cur_lo();
   endtask

   task automatic check_all();
      logic [15:0] w, e_dq;
      logic e_lo, e_hi, e_v;
      string tag;
      if (id_hv) w = (addr[AW-1:1] != '0) ? 16'hFFFF : (addr[0] ? 16'hB800 : 16'h00C2);
      else       w = spec_cell(addr);
      e_lo = !ce_n && !oe_n;
      e_hi = e_lo && word_mode;
      if (!e_lo)          e_dq = 16'h0;
      else if (word_mode) e_dq = w;
      else                e_dq = {8'h00, a_m1 ? w[15:8] : w[7:0]};
      e_v = e_lo && (m_cnt == 0) && (cur_hi() == m_hi) && (cur_lo() == m_lo);
      if (ce_n)                                tag = "R1";
      else if (oe_n)                           tag = "R2";
      else if (id_hv && addr[AW-1:1] != '0)    tag = "R7";
      else if (id_hv)                          tag = "R6";
      else if (word_mode)                      tag = "R3/R5";
      else                                     tag = "R4/R5";
      tests++;
      if (dq_out !== e_dq || lo_oe !== e_lo || hi_oe !== e_hi) begin
         fails++;
         $display("FAIL %s dq=%h lo=%b hi=%b expected dq=%h lo=%b hi=%b",
                  tag, dq_out, lo_oe, hi_oe, e_dq, e_lo, e_hi);
      end
      tests++;
      if (data_valid !== e_v) begin
         fails++;
         $display("FAIL R8/R9/R10 data_valid=%b expected %b (cnt model %0d)",
                  data_valid, e_v, m_cnt);
      end
   endtask

   task automatic cycle();
      #1 check_all();
      @(posedge clk);
      model_edge();
      #2;
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      // R11: reset state
      repeat (3) @(posedge clk);
      #2;
      tests++;
      if (data_valid !== 1'b0) begin
         fails++;
         $display("FAIL R11 data_valid=%b expected 0", data_valid);
      end
      rst_n = 1'b1;
      wait_cycles(2);  // deselected (R1), model syncs

      // R3/R5 word read, full latency R8
      ce_n = 0; oe_n = 0; word_mode = 1; addr = 6'd9;
      wait_cycles(FULL + 2);
      // R9 page move within the page
      addr = 6'd10;
      wait_cycles(PAGE + 2);
      // R5 blank location, same page
      addr = 6'd15;
      wait_cycles(3);
      // R3: a_m1 ignored in word mode
      a_m1 = 1;
      wait_cycles(2);
      // R4 byte mode, upper then lower half
      word_mode = 0; a_m1 = 1;
      wait_cycles(FULL + 1);
      a_m1 = 0;
      wait_cycles(PAGE + 1);
      // R2 output disable; oe does not reset timing (R10)
      oe_n = 1;
      wait_cycles(2);
      oe_n = 0;
      wait_cycles(1);
      // R6 identify codes, word and byte mode
      word_mode = 1; id_hv = 1; addr = 6'd0;
      wait_cycles(FULL + 1);
      addr = 6'd1;
      wait_cycles(PAGE + 1);
      word_mode = 0; a_m1 = 1;
      wait_cycles(FULL + 1);
      // R7 identify with other lines set
      word_mode = 1; addr = 6'd12;
      wait_cycles(FULL + 1);
      id_hv = 0;
      // R1 standby with oe low
      ce_n = 1;
      wait_cycles(3);
      ce_n = 0;
      wait_cycles(FULL + 1);

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom % 16;
         case (r)
            0: ce_n = ~ce_n;
            1: oe_n = ~oe_n;
            2, 3, 4: addr = AW'($urandom);
            5, 6, 7: addr[PW-1:0] = PW'($urandom);
            8: word_mode = ~word_mode;
            9: a_m1 = ~a_m1;
            10: begin
               id_hv = ~id_hv;
               if ($urandom % 2 == 0) addr = AW'($urandom % 2);
            end
            default: ;
         endcase
         if (ce_n && ($urandom % 4 == 0)) ce_n = 0;
         cycle();
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule